// File: doc/BRIEF.md
# Network controller mode register file

This block is the small control register file of an Ethernet-style controller. It holds a four-bit mode register, an initialization block address that can be reached at two address pairs, and a current receive buffer address. Software reads and writes these through a simple word-addressed bus. The contents can change only while the controller is stopped or suspended.

Start and stop pulses move the controller between its stopped and running states. When the controller starts, the mode bits decide whether the transmitter and receiver come on. The block also gives the effective full-duplex state, which loopback can force on. For each transmit frame, it decides whether a frame check sequence is appended, using the global disable bit and a per-frame request from the start-of-packet descriptor.

A hard reset is an active-low asynchronous input. A soft reset is a synchronous pulse. The two resets clear different sets of state.

Top module: `nic_mode_regs`

## Requirements
- R1: The register map uses word addresses: mode register at 0, initialization address low/high at 4/5, the same pair at 12/13, and receive buffer address low/high at 6/7. In the mode register, bit 0 is loopback, bit 1 is transmit disable, bit 2 is receive disable and bit 3 is FCS disable. A write takes effect only while the controller is stopped or `susp` is high. A write at any other time leaves every register unchanged.
- R2: When the FCS disable bit is 0, `frame_fcs` becomes 1 for every start-of-packet descriptor. When the bit is 1, `frame_fcs` becomes 0 unless that descriptor requests FCS. `frame_fcs` updates on the clock edge after the descriptor.
- R3: A descriptor with `txd_add_fcs` high and `txd_sop` high makes `frame_fcs` 1 whatever the FCS disable bit holds. Descriptors with `txd_sop` low do not change `frame_fcs`.
- R4: On a start pulse, `tx_on` becomes 1 on the next edge if transmit disable is 0, and stays 0 if it is 1.
- R5: On a start pulse, `rx_on` becomes 1 on the next edge if receive disable is 0, and stays 0 if it is 1. `rx_keep` equals `rx_valid` while `rx_on` is 1 and is 0 otherwise, so incoming data is dropped.
- R6: A stop pulse makes the controller stopped and clears `tx_on` and `rx_on` on the next edge. Stop wins over a simultaneous start.
- R7: Hard reset clears all four mode bits and the initialization address, and makes the controller stopped. Soft reset makes the controller stopped, clears `tx_on`, `rx_on` and the loopback bit, and keeps the other three mode bits. A stop pulse leaves loopback unchanged.
- R8: `fd_eff` is 1 whenever loopback is 1; otherwise it equals `cfg_fd`.
- R9: The two initialization address pairs share one storage. A write through either address is read back through both.
- R10: Bits 31:16 of every read are 0, whatever was written to them. Unmapped addresses read 0.
- R11: The receive buffer address keeps its contents through hard reset, soft reset and stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset pulse, synchronous |
| start_req | input | 1 | Start pulse |
| stop_req | input | 1 | Stop pulse |
| susp | input | 1 | Suspended state; opens the write window |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| cfg_fd | input | 1 | External full-duplex setting |
| txd_valid | input | 1 | Transmit descriptor presented |
| txd_sop | input | 1 | Descriptor marks start of packet |
| txd_add_fcs | input | 1 | Per-frame FCS request |
| rx_valid | input | 1 | Incoming receive data valid |
| tx_on | output | 1 | Transmitter running |
| rx_on | output | 1 | Receiver running |
| fd_eff | output | 1 | Effective full-duplex state |
| frame_fcs | output | 1 | FCS-append decision for the current frame |
| rx_keep | output | 1 | Receive data accepted |

## Verification
The hardest condition to bring about is the write lockout: it is visible only after the controller has really left the stopped state. The stimulus programs the registers, issues a start, and then attempts writes to the mode register and the address registers. It reads those registers back to show the old values. It then raises `susp` while the controller is still running and repeats the write, to show that the suspended window opens the registers without a stop. A separate sequence programs loopback with both disable bits set and then applies soft reset and hard reset. Reading back after each reset shows which bits each reset touched.

// File: rtl/nic_mode_regs.sv
module nic_mode_regs #(
  parameter int AW          = 4,
  parameter int HW          = 16,
  parameter int A_MODE      = 0,
  parameter int A_IBA_LO    = 4,
  parameter int A_IBA_HI    = 5,
  parameter int A_IBA_LO_B  = 12,
  parameter int A_IBA_HI_B  = 13,
  parameter int A_RXB_LO    = 6,
  parameter int A_RXB_HI    = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            start_req,
  input  logic            stop_req,
  input  logic            susp,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [2*HW-1:0] wr_data,
  output logic [2*HW-1:0] rd_data,
  input  logic            cfg_fd,
  input  logic            txd_valid,
  input  logic            txd_sop,
  input  logic            txd_add_fcs,
  input  logic            rx_valid,
  output logic            tx_on,
  output logic            rx_on,
  output logic            fd_eff,
  output logic            frame_fcs,
  output logic            rx_keep
);
  localparam int BW = 2 * HW;

  logic          stopped;
  logic          lpbk, dis_tx, dis_rx, no_fcs;
  logic [HW-1:0] iba_lo, iba_hi, rxb_lo, rxb_hi;

  wire wr_ok   = wr_en & (stopped | susp);
  wire hit_md  = (addr == AW'(A_MODE));
  wire hit_ilo = (addr == AW'(A_IBA_LO)) | (addr == AW'(A_IBA_LO_B));
  wire hit_ihi = (addr == AW'(A_IBA_HI)) | (addr == AW'(A_IBA_HI_B));
  wire hit_rlo = (addr == AW'(A_RXB_LO));
  wire hit_rhi = (addr == AW'(A_RXB_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped <= 1'b1;
      tx_on   <= 1'b0;
      rx_on   <= 1'b0;
      lpbk    <= 1'b0;
      dis_tx  <= 1'b0;
      dis_rx  <= 1'b0;
      no_fcs  <= 1'b0;
      iba_lo  <= '0;
      iba_hi  <= '0;
    end else if (soft_rst) begin
      stopped <= 1'b1;
      tx_on   <= 1'b0;
      rx_on   <= 1'b0;
      lpbk    <= 1'b0;
    end else begin
      if (stop_req) begin
        stopped <= 1'b1;
        tx_on   <= 1'b0;
        rx_on   <= 1'b0;
      end else if (start_req) begin
        stopped <= 1'b0;
        tx_on   <= ~dis_tx;
        rx_on   <= ~dis_rx;
      end
      if (wr_ok && hit_md) begin
        lpbk   <= wr_data[0];
        dis_tx <= wr_data[1];
        dis_rx <= wr_data[2];
        no_fcs <= wr_data[3];
      end
      if (wr_ok && hit_ilo) iba_lo <= wr_data[HW-1:0];
      if (wr_ok && hit_ihi) iba_hi <= wr_data[HW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && hit_rlo) rxb_lo <= wr_data[HW-1:0];
    if (wr_ok && hit_rhi) rxb_hi <= wr_data[HW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   frame_fcs <= 1'b0;
    else if (txd_valid && txd_sop) frame_fcs <= txd_add_fcs | ~no_fcs;
  end

  assign fd_eff  = lpbk | cfg_fd;
  assign rx_keep = rx_on & rx_valid;

  always_comb begin
    rd_data = '0;
    if (hit_md)       rd_data = BW'({no_fcs, dis_rx, dis_tx, lpbk});
    else if (hit_ilo) rd_data = BW'(iba_lo);
    else if (hit_ihi) rd_data = BW'(iba_hi);
    else if (hit_rlo) rd_data = BW'(rxb_lo);
    else if (hit_rhi) rd_data = BW'(rxb_hi);
  end

  a_r1_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stopped && !susp && !soft_rst) |=>
      $stable({lpbk, dis_tx, dis_rx, no_fcs}) && $stable(iba_lo) && $stable(iba_hi)
      && $stable(rxb_lo) && $stable(rxb_hi));

  a_r3_fcs_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_valid && txd_sop && txd_add_fcs) |=> frame_fcs);

  a_r4_tx_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_on) |-> ($past(start_req) && !$past(dis_tx)));

  a_r5_rx_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_on) |-> ($past(start_req) && !$past(dis_rx)));

  a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!tx_on && !rx_on && stopped));

  a_r7_soft_lpbk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!lpbk && stopped && !tx_on && !rx_on));

  a_r11_rxb_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wr_en) |=> ($stable(rxb_lo) && $stable(rxb_hi)));
endmodule

// File: tb/nic_mode_regs_bench.sv
`timescale 1ns/1ps
module nic_mode_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, start_req = 0, stop_req = 0, susp = 0, wr_en = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic cfg_fd = 0, txd_valid = 0, txd_sop = 0, txd_add_fcs = 0, rx_valid = 0;
  logic tx_on, rx_on, fd_eff, frame_fcs, rx_keep;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  int          q_sel[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  nic_mode_regs u_nic_mode_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start_req(start_req),
    .stop_req(stop_req), .susp(susp), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cfg_fd(cfg_fd),
    .txd_valid(txd_valid), .txd_sop(txd_sop), .txd_add_fcs(txd_add_fcs),
    .rx_valid(rx_valid), .tx_on(tx_on), .rx_on(rx_on), .fd_eff(fd_eff),
    .frame_fcs(frame_fcs), .rx_keep(rx_keep)
  );

  always begin
    wait (q_sel.size() != 0);
    #1;
    while (q_sel.size() != 0) begin
      automatic int          s = q_sel.pop_front();
      automatic logic [31:0] e = q_exp.pop_front();
      automatic string       t = q_tag.pop_front();
      automatic logic [31:0] a;
      case (s)
        0: a = rd_data;
        1: a = 32'(tx_on);
        2: a = 32'(rx_on);
        3: a = 32'(fd_eff);
        4: a = 32'(frame_fcs);
        default: a = 32'(rx_keep);
      endcase
      vectors++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic chk(input int sel, input logic [31:0] exp, input string tag);
    q_sel.push_back(sel); q_exp.push_back(exp); q_tag.push_back(tag);
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    chk(0, exp, tag);
  endtask

  task automatic pulse_start(); start_req = 1; cyc(); start_req = 0; endtask
  task automatic pulse_stop();  stop_req = 1;  cyc(); stop_req = 0;  endtask

  task automatic desc(input logic sop, input logic add);
    txd_valid = 1; txd_sop = sop; txd_add_fcs = add;
    cyc();
    txd_valid = 0; txd_sop = 0; txd_add_fcs = 0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    rd(4'd0, 32'h0, "R7 mode after hard reset");
    chk(1, 0, "R4 tx_on after reset");
    chk(2, 0, "R5 rx_on after reset");
    chk(3, 0, "R8 fd_eff with loopback off");
    cfg_fd = 1; chk(3, 1, "R8 fd_eff follows cfg_fd"); cfg_fd = 0;
    rd(4'd4, 32'h0, "R7 init address cleared");

    wr(4'd0, 32'h0000_0001);
    rd(4'd0, 32'h1, "R1 mode write while stopped");
    chk(3, 1, "R8 loopback forces full duplex");

    wr(4'd4, 32'hFFFF_1234);
    rd(4'd12, 32'h0000_1234, "R9 alias low via second pair");
    rd(4'd4, 32'h0000_1234, "R10 reserved upper bits zero");
    wr(4'd13, 32'h0000_ABCD);
    rd(4'd5, 32'h0000_ABCD, "R9 alias high via first pair");
    rd(4'd9, 32'h0, "R10 unmapped address reads zero");
    wr(4'd6, 32'h0000_5A5A);
    wr(4'd7, 32'h0000_C3C3);

    wr(4'd0, 32'h0000_0009);
    pulse_start();
    chk(1, 1, "R4 tx_on after start");
    chk(2, 1, "R5 rx_on after start");
    rx_valid = 1; chk(5, 1, "R5 rx_keep while receiving"); rx_valid = 0;

    wr(4'd0, 32'h0000_0000);
    wr(4'd4, 32'h0000_7777);
    wr(4'd6, 32'h0000_1111);
    rd(4'd0, 32'h9, "R1 mode write ignored while running");
    rd(4'd12, 32'h0000_1234, "R1 init address write ignored while running");
    rd(4'd6, 32'h0000_5A5A, "R1 rx buffer write ignored while running");

    desc(1, 0); chk(4, 0, "R2 FCS disabled, no request");
    desc(1, 1); chk(4, 1, "R3 per-frame request overrides");
    desc(0, 0); chk(4, 1, "R3 non-SOP descriptor ignored");
    desc(1, 0); chk(4, 0, "R2 FCS disabled again");

    susp = 1;
    wr(4'd0, 32'h0000_0000);
    rd(4'd0, 32'h0, "R1 write accepted while suspended");
    susp = 0;
    desc(1, 0); chk(4, 1, "R2 FCS enabled appends");

    wr(4'd0, 32'h0000_0001);
    rd(4'd0, 32'h0, "R1 write ignored after suspend ends");
    pulse_stop();
    chk(1, 0, "R6 tx_on cleared by stop");
    chk(2, 0, "R6 rx_on cleared by stop");

    wr(4'd0, 32'h0000_0007);
    pulse_stop();
    rd(4'd0, 32'h7, "R7 stop leaves loopback");
    pulse_start();
    chk(1, 0, "R4 tx_on held off by disable");
    chk(2, 0, "R5 rx_on held off by disable");
    rx_valid = 1; chk(5, 0, "R5 rx data dropped"); rx_valid = 0;
    stop_req = 1; start_req = 1; cyc(); stop_req = 0; start_req = 0;
    chk(1, 0, "R6 stop wins over start");

    soft_rst = 1; cyc(); soft_rst = 0;
    rd(4'd0, 32'h6, "R7 soft reset clears only loopback");
    rd(4'd6, 32'h0000_5A5A, "R11 rx buffer low kept by soft reset");
    rd(4'd13, 32'h0000_ABCD, "R9 init address kept by soft reset");

    rst_n = 0; cyc(); rst_n = 1; cyc();
    rd(4'd0, 32'h0, "R7 hard reset clears mode");
    rd(4'd7, 32'h0000_C3C3, "R11 rx buffer high kept by hard reset");
    rd(4'd5, 32'h0, "R7 hard reset clears init address");

    cyc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule